// File: doc/BRIEF.md
# Dual-Modulus Prescaler Extender

This block is a divide-by-four stage placed after a fast P/P+1 prescaler. Its clock is the prescaler output, and it drives the prescaler's modulus-select line. Together the two parts form a 4P/4P+1 divider. The chain keeps a ratio step of one but runs the programmable logic four times slower.

A two-bit state register counts from 0 to 3. The divided output is high in states 0 and 1 and low in states 2 and 3. Its falling edge is the one that clocks the next stage. The mode input comes from the synthesizer's programmable counter. When it is high, the modulus-select output stays high, so the prescaler always divides by P. When it is low, the modulus-select output drops for state 3 only. The prescaler therefore adds one extra count in one period out of four.

Reset is asynchronous and active low, and its release is synchronised inside the block.

Top module: `modulus_extender`

## Requirements
- R1: With reset released, `div_o` repeats with a period of exactly four rising edges of `clk_i`.
- R2: State 0 is the state in force during reset. `div_o` is 1 in states 0 and 1 and 0 in states 2 and 3, so it falls between the second and third states of each four-state pass.
- R3: While `mode_hi_i` is 1, `mc_o` is 1 in every state.
- R4: While `mode_hi_i` is 0, `mc_o` is 0 in state 3 only and 1 in states 0, 1 and 2.
- R5: `mc_o` is a combinational function of the registered state and `mode_hi_i`, so a change on `mode_hi_i` shows on `mc_o` before the next `clk_i` edge.
- R6: When `rst_ni` goes to 0, the state goes to 0 at once (`div_o`=1, `mc_o`=1). After `rst_ni` returns to 1, the state stays 0 for SYNC_STAGES rising edges (2 by default) and then advances on every edge.
- R7: With a P/P+1 prescaler (P=8, P+1 chosen when `mc_o`=0) feeding `clk_i`, the input-clock count between falling edges of `div_o` is 32 with `mode_hi_i`=1 and 33 with `mode_hi_i`=0.
- R8: After `mode_hi_i` changes at an arbitrary time, every period between falling edges of `div_o` is 32 or 33, with no extra or missing edges. Every complete period that starts after the change has the new ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock from the prescaler output |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_hi_i | input | 1 | Mode select: 1 gives 4P, 0 gives 4P+1 |
| div_o | output | 1 | Divided output; its falling edge clocks the next stage |
| mc_o | output | 1 | Modulus-select line back to the prescaler; 0 asks for P+1 |

## Verification
Both outputs are decoded without a register from the state and the mode input. A new `mode_hi_i` value therefore shows on `mc_o` within the same clock period. A state change shows one rising edge after it is caused. After reset release, the first advance is on the third edge.

The scoreboard phase drives inputs on the falling edge and pushes the expected pair for that period. It compares one time step later, before the next rising edge. The ratio phase runs the block from a modelled prescaler and counts input clocks between falling edges of `div_o`. The first period after a mode change may take either ratio; every later period must match the new mode.

// File: rtl/modext_pkg.sv
package modext_pkg;
  localparam int unsigned DEF_DIV  = 4;
  localparam int unsigned DEF_SYNC = 2;

  function automatic int unsigned st_w(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/modext_rst_sync.sv
module modext_rst_sync #(
  parameter int unsigned STAGES = modext_pkg::DEF_SYNC
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      assign sync_d = 1'b1;
    end else begin : g_chain
      assign sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/modext_counter.sv
module modext_counter #(
  parameter int unsigned DIV = modext_pkg::DEF_DIV,
  parameter int unsigned SW  = modext_pkg::st_w(DIV)
) (
  input  logic          clk_i,
  input  logic          arst_ni,
  output logic [SW-1:0] state_o
);
  localparam logic [SW-1:0] LAST = SW'(DIV - 1);

  logic [SW-1:0] st_q;
  logic [SW-1:0] st_d;

  // a power-of-two count wraps by itself; any other length compares
  generate
    if ((1 << SW) == DIV) begin : g_wrap
      always_comb st_d = st_q + 1'b1;
    end else begin : g_cmp
      always_comb st_d = (st_q == LAST) ? '0 : st_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) st_q <= '0;
    else          st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/modext_decode.sv
module modext_decode #(
  parameter int unsigned DIV      = modext_pkg::DEF_DIV,
  parameter int unsigned MC_STATE = DIV - 1,
  parameter int unsigned SW       = modext_pkg::st_w(DIV)
) (
  input  logic [SW-1:0] state_i,
  input  logic          mode_hi_i,
  output logic          div_o,
  output logic          mc_o
);
  localparam logic [SW-1:0] HALF   = SW'(DIV / 2);
  localparam logic [SW-1:0] SWALLOW = SW'(MC_STATE);

  // first half of the pass high, second half low
  always_comb div_o = (state_i < HALF);
  // the extra prescaler count is requested in one state only, and only in low mode
  always_comb mc_o  = mode_hi_i | (state_i != SWALLOW);
endmodule

// File: rtl/modulus_extender.sv
module modulus_extender #(
  parameter int unsigned DIV         = modext_pkg::DEF_DIV,
  parameter int unsigned SYNC_STAGES = modext_pkg::DEF_SYNC
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_hi_i,
  output logic div_o,
  output logic mc_o
);
  localparam int unsigned SW = modext_pkg::st_w(DIV);

  logic          rst_sync_n;
  logic [SW-1:0] state;

  modext_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  modext_counter #(.DIV(DIV), .SW(SW)) u_cnt (
    .clk_i   (clk_i),
    .arst_ni (rst_sync_n),
    .state_o (state)
  );

  modext_decode #(.DIV(DIV), .MC_STATE(DIV - 1), .SW(SW)) u_dec (
    .state_i   (state),
    .mode_hi_i (mode_hi_i),
    .div_o     (div_o),
    .mc_o      (mc_o)
  );
endmodule

// File: rtl/modext_checker.sv
module modext_checker #(
  parameter int unsigned DIV = modext_pkg::DEF_DIV
) (
  input logic clk_i,
  input logic rst_n,
  input logic mode_hi_i,
  input logic div_o,
  input logic mc_o
);
  logic [7:0] gap;
  logic       seen;
  logic       div_prev;
  logic       fall;

  assign fall = div_prev & ~div_o;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      gap      <= '0;
      seen     <= 1'b0;
      div_prev <= 1'b1;
    end else begin
      div_prev <= div_o;
      if (fall) begin
        gap  <= '0;
        seen <= 1'b1;
      end else if (gap != 8'hFF) begin
        gap <= gap + 1'b1;
      end
    end
  end

  // R1: falling edges of the divided output are DIV edges apart
  a_r1_period: assert property (@(posedge clk_i) disable iff (!rst_n)
    (fall && seen) |-> (gap == 8'(DIV - 1)));

  // R2: the output stays low on the edge after it falls, high after it rises
  a_r2_low_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(div_o) |=> !div_o);
  a_r2_high_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(div_o) |=> div_o);

  // R3: high mode never requests the extra count
  a_r3_mode_hi: assert property (@(posedge clk_i) disable iff (!rst_n)
    mode_hi_i |-> mc_o);

  // R4: the request lasts a single state and lies in the low half
  a_r4_single_low: assert property (@(posedge clk_i) disable iff (!rst_n)
    !mc_o |=> mc_o);
  a_r4_in_low_half: assert property (@(posedge clk_i) disable iff (!rst_n)
    !mc_o |-> !div_o);
endmodule

bind modulus_extender modext_checker #(.DIV(DIV)) u_chk (
  .clk_i     (clk_i),
  .rst_n     (rst_sync_n),
  .mode_hi_i (mode_hi_i),
  .div_o     (div_o),
  .mc_o      (mc_o)
);

// File: tb/modulus_extender_bench.sv
module modulus_extender_bench;
  localparam int P = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mode_hi_i = 1'b1;
  logic use_pre = 1'b0;
  logic pre_run = 1'b0;
  logic div_o, mc_o;
  logic dut_clk, pre_clk;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  // prescaler model: P input clocks per output period, P+1 when mc_o is low
  int pc;
  int pmod;
  always @(posedge clk) begin
    if (!pre_run) begin
      pc <= 0; pmod <= P;
    end else if (pc == pmod - 1) begin
      pc <= 0; pmod <= mc_o ? P : P + 1;
    end else begin
      pc <= pc + 1;
    end
  end
  assign pre_clk = pre_run && (pc < 4);
  assign dut_clk = use_pre ? pre_clk : clk;

  modulus_extender u_modulus_extender (
    .clk_i     (dut_clk),
    .rst_ni    (rst_ni),
    .mode_hi_i (mode_hi_i),
    .div_o     (div_o),
    .mc_o      (mc_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard
  typedef struct { logic d; logic m; string tag; } exp_t;
  exp_t q[$];
  int st = 0;
  int hold = 2;

  always @(negedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(div_o === e.d, {e.tag, " div_o"}, int'(div_o), int'(e.d));
      chk(mc_o === e.m, {e.tag, " mc_o"}, int'(mc_o), int'(e.m));
    end
  end

  task automatic tick(input logic mode, input logic rst, input string tag);
    exp_t e;
    @(negedge clk);
    rst_ni = rst;
    mode_hi_i = mode;
    if (!rst) begin st = 0; hold = 2; end
    e.d = (st < 2);
    e.m = mode | (st != 3);
    e.tag = tag;
    q.push_back(e);
    @(posedge clk);
    if (rst) begin
      if (hold > 0) hold--;
      else st = (st + 1) % 4;
    end
  endtask

  // ratio measurement between falling edges of div_o
  int cnt = 0;
  int last = 0;
  int periods[$];
  always @(posedge clk) cnt <= cnt + 1;
  always @(negedge div_o) if (use_pre && rst_ni) begin
    periods.push_back(cnt - last);
    last = cnt;
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // reset and its synchronised release (R6)
    repeat (3) tick(1'b1, 1'b0, "R6");
    repeat (3) tick(1'b1, 1'b1, "R6");
    // high mode: four-state pattern and no request (R1, R2, R3)
    repeat (4) tick(1'b1, 1'b1, "R1");
    repeat (4) tick(1'b1, 1'b1, "R2");
    repeat (4) tick(1'b1, 1'b1, "R3");
    // low mode: request in state 3 only (R4)
    repeat (8) tick(1'b0, 1'b1, "R4");
    // mode toggling every period: same-period response (R5)
    for (int i = 0; i < 12; i++) tick(i[0], 1'b1, "R5");
    // asynchronous reset in mid pass, then release (R6)
    tick(1'b0, 1'b1, "R4");
    tick(1'b0, 1'b0, "R6");
    tick(1'b0, 1'b0, "R6");
    repeat (8) tick(1'b0, 1'b1, "R6");
    @(negedge clk);
    #2;

    // ratio phase with the prescaler model
    rst_ni = 1'b0;
    mode_hi_i = 1'b1;
    use_pre = 1'b1;
    pre_run = 1'b1;
    repeat (40) @(negedge clk);
    rst_ni = 1'b1;
    repeat (200) @(negedge clk);
    periods.delete();
    repeat (33 * 6) @(negedge clk);
    chk(periods.size() >= 5, "R7 count high", periods.size(), 5);
    foreach (periods[i]) chk(periods[i] == 32, "R7 high ratio", periods[i], 32);

    // change to low mode at an odd point
    repeat (13) @(negedge clk);
    periods.delete();
    mode_hi_i = 1'b0;
    repeat (33 * 7) @(negedge clk);
    chk(periods.size() >= 5, "R8 count low", periods.size(), 5);
    foreach (periods[i]) begin
      if (i == 0) chk(periods[i] == 32 || periods[i] == 33, "R8 switch period", periods[i], 33);
      else        chk(periods[i] == 33, "R7 low ratio", periods[i], 33);
    end

    // change back to high mode at another point
    repeat (7) @(negedge clk);
    periods.delete();
    mode_hi_i = 1'b1;
    repeat (33 * 7) @(negedge clk);
    chk(periods.size() >= 5, "R8 count back", periods.size(), 5);
    foreach (periods[i]) begin
      if (i == 0) chk(periods[i] == 32 || periods[i] == 33, "R8 switch back", periods[i], 32);
      else        chk(periods[i] == 32, "R8 new ratio", periods[i], 32);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule